// File: doc/BRIEF.md
# Common-Start Multi-Hit Time Recorder

This block timestamps stop pulses on four independent channels against one shared start pulse. A start pulse opens an event and clears a coarse time counter, which then advances with the system clock. Each channel stores up to a configured number of hits. A hit that follows the previous accepted hit on the same channel too closely is dropped. When the configured window expires, the event closes. The stored lists then stream to a host one word at a time over a valid/ready handshake. When the last word has been taken, the block is ready for the next start.

A long-range setting widens the usable time span from 14 to 30 bits. In this setting the counter advances once every four clocks instead of every clock. All inputs are single-cycle synchronous pulses. Fine interpolation below one clock period is not part of the block.

Top module: `hit_rec_top`

## Requirements
- R1: After reset, `out_valid` and `out_last` are 0, `start_lost_o` is 0, and the block waits for a start.
- R2: In standard mode, a stop pulse sampled k clock edges after the edge that sampled the start gets timestamp k-1.
- R3: A channel keeps at most `cfg_max_hits` hits per event. A setting of 0 acts as 1, and a setting above 4 acts as 4. Further stops on that channel are dropped.
- R4: After a channel's first hit, a stop is kept only if at least `cfg_sep` clock cycles have passed since that channel's last kept hit. A rejected stop does not restart this spacing.
- R5: The event closes on the edge where the time count equals the window end. The window end is `cfg_window`, clamped to the range limit. Stops with a time count at or below the window end are kept. Stops on later edges are discarded.
- R6: Stop pulses sampled before the start, or on the same edge as the start, are not recorded.
- R7: A start that arrives while an event is open or not yet fully read is ignored and does not shift timestamps. It sets `start_lost_o`, which stays 1 until reset.
- R8: Readout visits channels 0 to 3 in turn. For each channel it sends a word holding the channel index, then a word holding the hit count, then that channel's timestamps in arrival order. A channel with no hits sends only its index and a count of 0. `out_last` is 1 only on the final word. After that word is accepted, `out_valid` drops to 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values.
- R10: With `cfg_long` set, the time count advances once every 4 clocks and the range limit is 2^30-1. Otherwise the count advances every clock and the limit is 2^14-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Common start pulse |
| stop_i | input | 4 | Stop pulses, one bit per channel |
| cfg_max_hits | input | 3 | Hit limit per channel (clamped to 1..4) |
| cfg_sep | input | 8 | Minimum spacing between kept hits, in clock cycles |
| cfg_window | input | 30 | Window end in time-count units |
| cfg_long | input | 1 | Long-range setting |
| out_ready | input | 1 | Host accepts the current word |
| out_valid | output | 1 | Readout word present |
| out_data | output | 30 | Index, count or timestamp word |
| out_last | output | 1 | Final word of the event |
| start_lost_o | output | 1 | Sticky: a start was ignored |

## Verification
A wrong hit counter or spacing counter shows up in the count word and in the timestamp list of the very next readout. A timestamp off by one edge, or a window that closes one edge early or late, appears as a shifted or missing final timestamp in that same event. A readout sequencer that slips changes the order of the index, count and timestamp words, or moves `out_last`, within the first channel it serves. A stall that corrupts data becomes visible in the word presented on the next cycle. A lost-start flag that does not stick, or a start that restarts the counter, shows at the ports in the same event.

// File: rtl/hr_pkg.sv
package hr_pkg;
  localparam int NCH     = 4;
  localparam int MAXH    = 4;
  localparam int TW_STD  = 14;
  localparam int TW_LONG = 30;
  localparam int LR_DIV  = 4;
  localparam int SEPW    = 8;
  localparam int HCW     = $clog2(MAXH + 1);

  typedef enum logic [1:0] {EV_IDLE, EV_OPEN, EV_READ} ev_state_t;

  // Requested window clamped to the range limit of the selected mode.
  function automatic logic [TW_LONG-1:0] win_end(input logic [TW_LONG-1:0] win,
                                                 input logic lng);
    logic [TW_LONG-1:0] lim;
    lim = lng ? {TW_LONG{1'b1}} : ((TW_LONG'(1) << TW_STD) - TW_LONG'(1));
    return (win > lim) ? lim : win;
  endfunction

  // Configured hit limit clamped to 1..MAXH.
  function automatic logic [HCW-1:0] eff_hits(input logic [HCW-1:0] cfg);
    if (cfg == '0) return HCW'(1);
    if (cfg > HCW'(MAXH)) return HCW'(MAXH);
    return cfg;
  endfunction
endpackage

// File: rtl/hr_timebase.sv
module hr_timebase #(
  parameter int TW  = hr_pkg::TW_LONG,
  parameter int DIV = hr_pkg::LR_DIV
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic          long_mode,
  input  logic [TW-1:0] win_end,
  output logic [TW-1:0] t_o,
  output logic          close_o
);
  localparam int PRW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PRW-1:0] pre;
  logic           tick;

  assign tick    = !long_mode || (pre == PRW'(DIV - 1));
  assign close_o = run && tick && (t_o == win_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      t_o <= '0;
    end else if (clear) begin
      pre <= '0;
      t_o <= '0;
    end else if (run) begin
      pre <= (pre == PRW'(DIV - 1)) ? '0 : pre + PRW'(1);
      if (tick) t_o <= t_o + TW'(1);
    end
  end

  AST_T_WITHIN: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (t_o <= win_end)); // R5
endmodule

// File: rtl/hr_channel.sv
module hr_channel #(
  parameter int MAXH = hr_pkg::MAXH,
  parameter int TW   = hr_pkg::TW_LONG,
  parameter int SEPW = hr_pkg::SEPW,
  parameter int CW   = hr_pkg::HCW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               arm,
  input  logic               stop,
  input  logic [TW-1:0]      tstamp,
  input  logic [CW-1:0]      max_hits,
  input  logic [SEPW-1:0]    sep,
  output logic [CW-1:0]      count_o,
  output logic [MAXH*TW-1:0] hits_o,
  output logic               accept_o
);
  logic [SEPW-1:0] gap;
  logic            room, spaced;

  assign room     = count_o < max_hits;
  assign spaced   = (count_o == '0) || (gap >= sep);
  assign accept_o = arm && stop && room && spaced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
      gap     <= '0;
      hits_o  <= '0;
    end else if (clear) begin
      count_o <= '0;
      gap     <= '0;
    end else if (accept_o) begin
      hits_o[int'(count_o)*TW +: TW] <= tstamp;
      count_o <= count_o + CW'(1);
      gap     <= SEPW'(1);
    end else if (gap != {SEPW{1'b1}}) begin
      gap <= gap + SEPW'(1);
    end
  end

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> (count_o <= max_hits)); // R3
  AST_ACCEPT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> (count_o == $past(count_o) + CW'(1))); // R3
endmodule

// File: rtl/hr_readout.sv
module hr_readout #(
  parameter int NCH  = hr_pkg::NCH,
  parameter int MAXH = hr_pkg::MAXH,
  parameter int TW   = hr_pkg::TW_LONG,
  parameter int CW   = hr_pkg::HCW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   go,
  input  logic [NCH*CW-1:0]      counts,
  input  logic [NCH*MAXH*TW-1:0] hits,
  input  logic                   ready,
  output logic                   valid,
  output logic [TW-1:0]          data,
  output logic                   last,
  output logic                   done
);
  localparam int XW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int PW = $clog2(MAXH + 3);

  logic [XW-1:0] ch;
  logic [PW-1:0] ph;
  logic [CW-1:0] cur_cnt;
  logic [CW-1:0] hidx;
  logic          end_of_ch, xfer;

  assign cur_cnt   = counts[int'(ch)*CW +: CW];
  assign hidx      = CW'(ph - PW'(2));
  assign end_of_ch = (ph == PW'(cur_cnt) + PW'(1));
  assign valid     = go;
  assign last      = go && end_of_ch && (ch == XW'(NCH - 1));
  assign xfer      = valid && ready;
  assign done      = xfer && last;

  always_comb begin
    if (ph == '0)           data = TW'(ch);
    else if (ph == PW'(1))  data = TW'(cur_cnt);
    else                    data = hits[(int'(ch)*MAXH + int'(hidx))*TW +: TW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch <= '0;
      ph <= '0;
    end else if (!go) begin
      ch <= '0;
      ph <= '0;
    end else if (xfer) begin
      if (end_of_ch) begin
        ch <= ch + XW'(1);
        ph <= '0;
      end else begin
        ph <= ph + PW'(1);
      end
    end
  end

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data))); // R9
endmodule

// File: rtl/hit_rec_top.sv
module hit_rec_top #(
  parameter int NCH  = hr_pkg::NCH,
  parameter int MAXH = hr_pkg::MAXH,
  parameter int TW   = hr_pkg::TW_LONG,
  parameter int DIV  = hr_pkg::LR_DIV,
  parameter int SEPW = hr_pkg::SEPW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [NCH-1:0]         stop_i,
  input  logic [hr_pkg::HCW-1:0] cfg_max_hits,
  input  logic [SEPW-1:0]        cfg_sep,
  input  logic [TW-1:0]          cfg_window,
  input  logic                   cfg_long,
  input  logic                   out_ready,
  output logic                   out_valid,
  output logic [TW-1:0]          out_data,
  output logic                   out_last,
  output logic                   start_lost_o
);
  import hr_pkg::*;
  localparam int CW = HCW;

  ev_state_t             state;
  logic                  ev_begin, ev_close, ev_done, start_drop;
  logic [TW-1:0]         t_now, w_end;
  logic [CW-1:0]         lim_hits;
  logic [NCH*CW-1:0]     counts;
  logic [NCH*MAXH*TW-1:0] hits;
  logic [NCH-1:0]        accepts;

  assign ev_begin   = start_i && (state == EV_IDLE);
  assign start_drop = start_i && (state != EV_IDLE);
  assign w_end      = win_end(cfg_window, cfg_long);
  assign lim_hits   = eff_hits(cfg_max_hits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= EV_IDLE;
      start_lost_o <= 1'b0;
    end else begin
      if (start_drop) start_lost_o <= 1'b1;
      case (state)
        EV_IDLE: if (ev_begin) state <= EV_OPEN;
        EV_OPEN: if (ev_close) state <= EV_READ;
        EV_READ: if (ev_done)  state <= EV_IDLE;
        default: state <= EV_IDLE;
      endcase
    end
  end

  hr_timebase #(.TW(TW), .DIV(DIV)) u_tb (
    .clk(clk), .rst_n(rst_n), .clear(ev_begin), .run(state == EV_OPEN),
    .long_mode(cfg_long), .win_end(w_end), .t_o(t_now), .close_o(ev_close));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    hr_channel #(.MAXH(MAXH), .TW(TW), .SEPW(SEPW), .CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .clear(ev_begin), .arm(state == EV_OPEN),
      .stop(stop_i[g]), .tstamp(t_now), .max_hits(lim_hits), .sep(cfg_sep),
      .count_o(counts[g*CW +: CW]), .hits_o(hits[g*MAXH*TW +: MAXH*TW]),
      .accept_o(accepts[g]));
  end

  hr_readout #(.NCH(NCH), .MAXH(MAXH), .TW(TW), .CW(CW)) u_ro (
    .clk(clk), .rst_n(rst_n), .go(state == EV_READ), .counts(counts),
    .hits(hits), .ready(out_ready), .valid(out_valid), .data(out_data),
    .last(out_last), .done(ev_done));

  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    start_lost_o |=> start_lost_o); // R7
  AST_NO_HIT_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != EV_OPEN) |-> (accepts == '0)); // R6
  AST_IGNORED_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_drop && state == EV_OPEN) |=> (state != EV_IDLE)); // R7
endmodule

// File: tb/hit_rec_top_tb.sv
module hit_rec_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  stop_i = '0;
  logic [2:0]  cfg_max_hits = 3'd4;
  logic [7:0]  cfg_sep = 8'd2;
  logic [29:0] cfg_window = 30'd40;
  logic        cfg_long = 1'b0;
  logic        out_ready = 1'b0;
  logic        out_valid, out_last, start_lost_o;
  logic [29:0] out_data;

  int n_chk = 0, n_err = 0;
  bit wd_hit = 0;

  int ev_c[0:15]; logic [3:0] ev_m[0:15]; int n_ev;
  int xs_c[0:3];  int n_xs;
  int exp_w[0:63]; int n_exp;

  always #2 clk = ~clk;

  hit_rec_top u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .cfg_max_hits(cfg_max_hits), .cfg_sep(cfg_sep), .cfg_window(cfg_window),
    .cfg_long(cfg_long), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .start_lost_o(start_lost_o));

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start_i = 0; stop_i = '0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic add_stop(input int c, input logic [3:0] m);
    ev_c[n_ev] = c; ev_m[n_ev] = m; n_ev++;
  endtask

  // Bench model: expected word stream from R2..R8, R10.
  task automatic build_expect();
    int mx, we, closecyc, sep;
    mx  = (cfg_max_hits == 0) ? 1 : (cfg_max_hits > 4) ? 4 : int'(cfg_max_hits);
    we  = cfg_long ? int'(cfg_window) : ((cfg_window > 30'd16383) ? 16383 : int'(cfg_window));
    closecyc = cfg_long ? 4*we + 3 : we;
    sep = int'(cfg_sep);
    n_exp = 0;
    for (int ch = 0; ch < 4; ch++) begin
      int cnt, lastc; int ts[0:3];
      cnt = 0; lastc = 0;
      for (int e = 0; e < n_ev; e++) begin
        int c; c = ev_c[e];
        if (ev_m[e][ch] && c >= 1 && (c - 1) <= closecyc && cnt < mx &&
            (cnt == 0 || (c - lastc) >= sep)) begin
          ts[cnt] = cfg_long ? (c - 1) / 4 : (c - 1);
          cnt++; lastc = c;
        end
      end
      exp_w[n_exp] = ch; n_exp++;
      exp_w[n_exp] = cnt; n_exp++;
      for (int i = 0; i < cnt; i++) begin exp_w[n_exp] = ts[i]; n_exp++; end
    end
  endtask

  task automatic run_event(input string req, input int len, input bit stall, input bit exp_lost);
    int k, cyc;
    build_expect();
    for (int c = 0; c < len; c++) begin
      logic st; logic [3:0] m;
      st = (c == 0); m = '0;
      for (int x = 0; x < n_xs; x++) if (xs_c[x] == c) st = 1'b1;
      for (int e = 0; e < n_ev; e++) if (ev_c[e] == c) m = m | ev_m[e];
      start_i = st; stop_i = m;
      @(negedge clk);
    end
    start_i = 0; stop_i = '0;
    k = 0; cyc = 0;
    while (k < n_exp && cyc < 400) begin
      logic rdy;
      rdy = stall ? cyc[0] : 1'b1;
      out_ready = rdy;
      if (out_valid && rdy) begin
        check({req, " word"}, out_data, exp_w[k]);
        check({req, " R8 last"}, out_last, (k == n_exp - 1));
        k++;
      end
      @(negedge clk);
      cyc++;
    end
    out_ready = 0;
    check({req, " R8 word total"}, k, n_exp);
    check({req, " R8 valid after last"}, out_valid, 0);
    check({req, " R7 lost flag"}, start_lost_o, exp_lost);
    n_ev = 0; n_xs = 0;
  endtask

  task automatic t_reset();
    check("R1 valid", out_valid, 0);
    check("R1 last", out_last, 0);
    check("R1 lost", start_lost_o, 0);
  endtask

  task automatic t_basic(input bit stall);
    cfg_max_hits = 4; cfg_sep = 2; cfg_window = 40; cfg_long = 0;
    add_stop(3, 4'b0001); add_stop(5, 4'b0011); add_stop(6, 4'b0001);
    add_stop(7, 4'b0001); add_stop(10, 4'b1000);
    run_event(stall ? "R9 stall R2 R4" : "R2 R4 R8 basic", 50, stall, 0);
  endtask

  task automatic t_clamp();
    cfg_sep = 2; cfg_window = 30; cfg_long = 0;
    cfg_max_hits = 0;
    add_stop(2, 4'b0010); add_stop(5, 4'b0010); add_stop(9, 4'b0010);
    run_event("R3 zero->1", 40, 0, 0);
    cfg_max_hits = 7;
    for (int i = 1; i <= 6; i++) add_stop(2*i, 4'b0001);
    run_event("R3 over->4", 40, 0, 0);
    cfg_max_hits = 3; cfg_sep = 5;
    add_stop(2, 4'b0100); add_stop(4, 4'b0100); add_stop(7, 4'b0100);
    add_stop(9, 4'b0100); add_stop(12, 4'b0100); add_stop(20, 4'b0100);
    run_event("R3 R4 limit3 sep5", 40, 0, 0);
  endtask

  task automatic t_window();
    cfg_max_hits = 4; cfg_sep = 2; cfg_window = 10; cfg_long = 0;
    stop_i = 4'b1111; @(negedge clk); stop_i = '0; @(negedge clk);
    add_stop(0, 4'b0010); add_stop(11, 4'b0001); add_stop(12, 4'b0100);
    run_event("R5 R6 window", 20, 0, 0);
  endtask

  task automatic t_lost();
    cfg_max_hits = 4; cfg_sep = 2; cfg_window = 12; cfg_long = 0;
    xs_c[0] = 4; xs_c[1] = 18; n_xs = 2;
    add_stop(6, 4'b0100);
    run_event("R7 lost start", 20, 0, 1);
    do_reset();
    check("R7 flag cleared by reset", start_lost_o, 0);
  endtask

  task automatic t_long();
    cfg_max_hits = 4; cfg_sep = 2; cfg_window = 3; cfg_long = 1;
    add_stop(1, 4'b0001); add_stop(6, 4'b0001); add_stop(16, 4'b0001);
    add_stop(17, 4'b0010);
    run_event("R10 long", 24, 0, 0);
    cfg_long = 0;
  endtask

  task automatic t_limit();
    cfg_max_hits = 4; cfg_sep = 2; cfg_window = 30'h3FFFFFFF; cfg_long = 0;
    add_stop(100, 4'b0001); add_stop(16384, 4'b1000); add_stop(16385, 4'b0001);
    run_event("R5 R10 range limit", 16392, 0, 0);
  endtask

  initial begin
    n_ev = 0; n_xs = 0;
    do_reset();
    t_reset();
    t_basic(0);
    t_basic(1);
    t_clamp();
    t_window();
    t_long();
    t_limit();
    t_lost();
    if (!wd_hit) begin
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    wd_hit = 1;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule